// File: doc/BRIEF.md
# Pattern Output Start-Arming Control

This block holds the write-only control byte of a pattern-output section. It also holds the start-enable logic that launches that section. A single bus write port reaches two locations. The control location sets these controls:

- RAM loading
- counter enabling
- input sampling edge
- co-start mode
- drive/load mode
- clock-source code

The start location requests or withdraws the start enable.

When co-start mode is off, a start request raises the start enable at once. When co-start mode is on, the request is only remembered. The enable then rises when the bus performs the write that arms the input section, so both sections begin in the same cycle. The block decodes that arming write itself and presents it as an active-low strobe. The start enable can be withdrawn only while co-start mode is off.

Top module: `pattern_start_arm`

## Requirements
- R1: A synchronous active-high reset clears the control byte to 0x00, drops the start enable and discards any remembered start request.
- R2: A write to address 0x01 loads the control byte on the next rising edge. The control outputs are driven from its bits: bit 7 = load-RAM (active low), bit 6 = counter enable (active low), bit 5 = edge select (1 = falling), bit 4 = co-start, bit 3 = drive (1) / load (0).
- R3: A write happens only when chip select (active low) is low and the write strobe is high. A write to any address other than 0x01 or 0x11 changes no register.
- R4: With co-start off, a write to 0x11 with data bit 0 = 1 sets the start enable on the next edge and discards any remembered request.
- R5: With co-start on, a write to 0x11 with data bit 0 = 1 leaves the start enable unchanged. If the enable is low, the request is remembered.
- R6: The arm strobe output is low, combinationally, exactly when chip select is low, the write strobe is high, address bits 3..1 are all zero, data bit 0 is 0 and data bit 1 is 1.
- R7: With co-start on and a request remembered, a cycle with the arm strobe low sets the start enable on the next edge and consumes the request. A remembered request survives cycles in which co-start is off but no start write occurs.
- R8: With co-start off, a write to 0x11 with data bit 0 = 0 clears the start enable and any remembered request on the next edge.
- R9: With co-start on, a write to 0x11 with data bit 0 = 0 is ignored: the start enable stays as it was.
- R10: The clock-source code output equals control bits 2..0 unchanged (000 internal oscillator, 001 external sync, 010 RAM strobe, 011 driver clock, 100 decrement, others ground).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| load_ram_n | output | 1 | Load vector RAM, active low |
| cnt_en_n | output | 1 | Address counter enable, active low |
| edge_fall | output | 1 | 1 = sample input on falling edge |
| co_start | output | 1 | Co-start mode |
| drive_mode | output | 1 | 1 = drive, 0 = load |
| clk_sel | output | 3 | Clock-source code |
| start_ena | output | 1 | Start enable level |
| in_arm_n | output | 1 | Decoded input-arm strobe, active low |

## Verification
The hardest situation to reach is a remembered co-start request that meets an arm strobe. Before that meeting, co-start may have been toggled, or a withdrawal may have been attempted and ignored. Random traffic rarely strings these writes together. The stimulus therefore draws addresses mostly from 0x01, 0x11 and the arm pattern, and biases data toward bit 0/bit 1 pairs. Directed sequences then walk the request through setting, an ignored clear, a co-start toggle and the firing arm.

// File: rtl/pattern_start_arm.sv
module pattern_start_arm #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(8'h01),
  parameter logic [ADDR_W-1:0] START_ADDR = ADDR_W'(8'h11)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              load_ram_n,
  output logic              cnt_en_n,
  output logic              edge_fall,
  output logic              co_start,
  output logic              drive_mode,
  output logic [2:0]        clk_sel,
  output logic              start_ena,
  output logic              in_arm_n
);
  localparam int CO_BIT = 4;

  logic [7:0] ctrl_q;
  logic       start_q, pend_q;
  logic       wr, wr_ctrl, wr_start, arm;

  assign wr       = !bus_cs_n && bus_we;
  assign wr_ctrl  = wr && (bus_addr == CTRL_ADDR);
  assign wr_start = wr && (bus_addr == START_ADDR);
  assign arm      = wr && (bus_addr[3:1] == 3'b000) && !bus_wdata[0] && bus_wdata[1];
  assign in_arm_n = !arm;

  assign load_ram_n = ctrl_q[7];
  assign cnt_en_n   = ctrl_q[6];
  assign edge_fall  = ctrl_q[5];
  assign co_start   = ctrl_q[CO_BIT];
  assign drive_mode = ctrl_q[3];
  assign clk_sel    = ctrl_q[2:0];
  assign start_ena  = start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (!ctrl_q[CO_BIT]) begin
        if (wr_start) begin
          start_q <= bus_wdata[0];
          pend_q  <= 1'b0;
        end
      end else begin
        if (wr_start && bus_wdata[0] && !start_q) pend_q <= 1'b1;
        if (pend_q && arm) begin
          start_q <= 1'b1;
          pend_q  <= 1'b0;
        end
      end
    end
  end

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ({load_ram_n, cnt_en_n, edge_fall, co_start, drive_mode, clk_sel} == $past(bus_wdata)));
  // R4
  co_off_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_start && !co_start && bus_wdata[0]) |=> start_ena);
  // R8
  co_off_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_start && !co_start && !bus_wdata[0]) |=> (!start_ena && !pend_q));
  // R9
  co_on_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (co_start && !(pend_q && !in_arm_n)) |=> $stable(start_ena));
  // R7
  arm_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (co_start && pend_q && !in_arm_n) |=> (start_ena && !pend_q));
endmodule

// File: tb/pattern_start_arm_tb.sv
module pattern_start_arm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 3000;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_cs_n = 1'b1, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic load_ram_n, cnt_en_n, edge_fall, co_start, drive_mode, start_ena, in_arm_n;
  logic [2:0] clk_sel;

  int checks = 0, errors = 0;
  logic [7:0] m_ctrl = '0;
  logic m_start = 1'b0, m_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_start_arm u_dut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .load_ram_n(load_ram_n), .cnt_en_n(cnt_en_n), .edge_fall(edge_fall),
    .co_start(co_start), .drive_mode(drive_mode), .clk_sel(clk_sel),
    .start_ena(start_ena), .in_arm_n(in_arm_n)
  );

  function automatic logic exp_arm_n(logic cs_n, logic we, logic [7:0] a, logic [7:0] d);
    return !(!cs_n && we && a[3:1] == 3'b000 && !d[0] && d[1]);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R2 load_ram_n", {7'd0, load_ram_n}, {7'd0, m_ctrl[7]});
    chk("R2 cnt_en_n", {7'd0, cnt_en_n}, {7'd0, m_ctrl[6]});
    chk("R2 edge_fall", {7'd0, edge_fall}, {7'd0, m_ctrl[5]});
    chk("R2 co_start", {7'd0, co_start}, {7'd0, m_ctrl[4]});
    chk("R2 drive_mode", {7'd0, drive_mode}, {7'd0, m_ctrl[3]});
    chk("R10 clk_sel", {5'd0, clk_sel}, {5'd0, m_ctrl[2:0]});
    chk("R4 R5 R7 R8 R9 start_ena", {7'd0, start_ena}, {7'd0, m_start});
  endtask

  // one bus cycle: drive after negedge, update model at posedge, compare at next negedge
  task automatic step(logic r, logic cs_n, logic we, logic [7:0] a, logic [7:0] d);
    logic wr, wa;
    rst = r; bus_cs_n = cs_n; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    chk("R6 in_arm_n", {7'd0, in_arm_n}, {7'd0, exp_arm_n(cs_n, we, a, d)});
    @(posedge clk);
    wr = !cs_n && we;
    wa = !exp_arm_n(cs_n, we, a, d);
    if (r) begin
      m_ctrl = '0; m_start = 1'b0; m_pend = 1'b0;
    end else begin
      logic co;
      co = m_ctrl[4];
      if (wr && a == 8'h01) m_ctrl = d;
      if (!co) begin
        if (wr && a == 8'h11) begin m_start = d[0]; m_pend = 1'b0; end
      end else begin
        if (wr && a == 8'h11 && d[0] && !m_start) m_pend = 1'b1;
        else if (m_pend && wa) begin m_start = 1'b1; m_pend = 1'b0; end
      end
    end
    @(negedge clk);
    check_outs();
  endtask

  task automatic wr8(logic [7:0] a, logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    #(CLK_PERIOD*30000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    // R1 reset state
    chk("R1 ctrl after reset", {load_ram_n, cnt_en_n, edge_fall, co_start, drive_mode, clk_sel}, 8'h00);
    chk("R1 start after reset", {7'd0, start_ena}, 8'h00);

    // R4 immediate start, R8 clear
    wr8(8'h11, 8'h01); chk("R4 set with co-start off", {7'd0, start_ena}, 8'h01);
    wr8(8'h11, 8'h00); chk("R8 clear with co-start off", {7'd0, start_ena}, 8'h00);

    // R3 ignored writes: cs high, we low, wrong address
    step(1'b0, 1'b1, 1'b1, 8'h01, 8'hFF);
    step(1'b0, 1'b0, 1'b0, 8'h11, 8'h01);
    wr8(8'h21, 8'hFF); wr8(8'h10, 8'h01);
    chk("R3 ignored ctrl", {load_ram_n, cnt_en_n, edge_fall, co_start, drive_mode, clk_sel}, 8'h00);
    chk("R3 ignored start", {7'd0, start_ena}, 8'h00);

    // R10 each clock code
    for (int k = 0; k < 8; k++) begin
      wr8(8'h01, 8'(k) | 8'hA8);
      chk("R10 clk code", {5'd0, clk_sel}, 8'(k));
    end

    // R5 R9 R7: co-start on, request held, clear ignored, toggle, arm fires
    wr8(8'h01, 8'h10);
    wr8(8'h11, 8'h01); chk("R5 held off", {7'd0, start_ena}, 8'h00);
    wr8(8'h11, 8'h00); chk("R9 clear ignored (low)", {7'd0, start_ena}, 8'h00);
    wr8(8'h01, 8'h00); wr8(8'h01, 8'h10);
    repeat (3) step(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
    chk("R5 still off", {7'd0, start_ena}, 8'h00);
    wr8(8'h00, 8'h02); chk("R7 arm fires", {7'd0, start_ena}, 8'h01);
    wr8(8'h11, 8'h00); chk("R9 clear ignored (high)", {7'd0, start_ena}, 8'h01);
    wr8(8'h01, 8'h00); wr8(8'h11, 8'h00);
    chk("R8 clear after co-start off", {7'd0, start_ena}, 8'h00);

    // R1 reset discards a pending request
    wr8(8'h01, 8'h10); wr8(8'h11, 8'h01);
    step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    wr8(8'h01, 8'h10); wr8(8'h00, 8'h02);
    chk("R1 pending discarded", {7'd0, start_ena}, 8'h00);

    // constrained random traffic
    for (int i = 0; i < NRAND; i++) begin
      logic [7:0] a, d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 3) ? 8'h01 : (sel < 7) ? 8'h11 : (sel < 9) ? 8'h00 : 8'($urandom);
      d = 8'($urandom);
      if ($urandom_range(0, 1) == 0) d[1:0] = 2'b10;
      step($urandom_range(0, 199) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 7) != 0, a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule